// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block builds the eight-bit status word that a parallel flash places on its data bus when the host reads the part while an internal program or erase algorithm is active, or while an erase is suspended. The sequencer supplies the operation kind, the current phase, the suspend state, bit 7 of the byte being programmed and, with each read strobe, whether the read address falls inside a sector selected for erase. The block answers with the status bits and a flag telling the data path to pass array data through instead.

Several status bits carry different meanings. Bit 7 is a polling bit: it reads the complement of the programmed bit, or 0 for erase. Bit 6 flips on every status read while work is in progress. Bit 5 flags a time-limit failure. Bit 3 marks the end of the sector-erase collection window. Bit 2 flips only on reads aimed at sectors under erase. The flip state moves only on the rising edge of the read strobe. A failure stays visible until a reset command clears it.

Top module: `status_byte_gen`

## Requirements
- R1: With operation program (op_kind 01) in phase running (phase 01), status bit 7 equals the inverse of prog_d7, and bits 5, 4, 3, 2, 1 and 0 read 0.
- R2: With chip erase (op_kind 10) or sector erase (op_kind 11) in progress, status bit 7 reads 0 and use_array is 0.
- R3: While an operation is in progress, status bit 6 takes the opposite value on each successive read. When the phase is done (phase 10), use_array is 1 and status is 0x00.
- R4: The flip state of bits 6 and 2 changes only on a rising edge of rd_stb. Idle clock cycles, and cycles with rd_stb held high after its rise, leave it unchanged.
- R5: In phase failed (phase 11), bit 5 reads 1, bit 6 keeps flipping on each read, and bit 7 keeps its in-progress value.
- R6: After a failure, the failed status (bit 5 = 1, use_array = 0) persists after the phase input leaves failed. It ends only when rst_cmd is pulsed, after which use_array returns to 1.
- R7: For sector erase, bit 3 reads 0 in the collection window (phase 00) and 1 once running. For chip erase, bit 3 reads 0.
- R8: During chip erase, bit 2 flips on every read. During sector erase, bit 2 flips only on reads with rd_in_erase high and holds on other reads.
- R9: With suspended high and an erase operation, a read with rd_in_erase high gives bit 7 = 1, bit 6 unchanged between reads, bit 2 flipping, and use_array = 0.
- R10: With suspended high and an erase operation, a read with rd_in_erase low gives use_array = 1.
- R11: With suspended high and op_kind program running, bit 7 reads the inverse of prog_d7, bit 6 flips on each read, and bit 5 reads 0.
- R12: After reset, with op_kind none (00), use_array is 1 and status is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 2 | 00 none, 01 program, 10 chip erase, 11 sector erase |
| phase | input | 2 | 00 collection window, 01 running, 10 done, 11 failed |
| suspended | input | 1 | Erase is suspended |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| rd_stb | input | 1 | Read strobe; a rising edge marks one read |
| rd_in_erase | input | 1 | Read address lies in a sector selected for erase |
| rst_cmd | input | 1 | Reset command pulse; clears a held failure |
| status | output | 8 | Status byte |
| use_array | output | 1 | 1: drive array data instead of status |

## Verification
The hardest case to reach is the held failure. The phase input must first show failed, then fall back to done while the block keeps reporting the failure. Only then may the reset command release it. The stimulus walks through these three steps in order and reads at each step. The suspended-read case is also difficult, because bit 6 must stay frozen while bit 2 flips. To cover it, the bench makes two reads into an erased sector and compares the two bytes bit by bit. A read held high over several cycles checks that only the strobe edge advances the flip state.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_CHIP = 2'd2,
    OP_SECT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_WINDOW = 2'd0,
    PH_RUN    = 2'd1,
    PH_DONE   = 2'd2,
    PH_FAIL   = 2'd3
  } phase_e;

  localparam int STAT_W  = 8;
  localparam int B_POLL  = 7;
  localparam int B_TOG   = 6;
  localparam int B_LIMIT = 5;
  localparam int B_WIN   = 3;
  localparam int B_SECT  = 2;
  localparam int N_TOG   = 2;
  localparam int T_MAIN  = 0;
  localparam int T_SECT  = 1;
endpackage

// File: rtl/sbg_rst_sync.sv
module sbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/sbg_read_edge.sv
module sbg_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  output logic rise
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_stb;
  end

  assign rise = rd_stb & ~rd_q;
endmodule

// File: rtl/sbg_toggle.sv
module sbg_toggle #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic [N-1:0] adv,
  output logic [N-1:0] tog
);
  logic [N-1:0] tog_q;
  logic [N-1:0] tog_d;
  logic [N-1:0] tog_en;

  for (genvar i = 0; i < N; i++) begin : g_tog
    always_comb begin
      tog_en[i] = rise & adv[i];
      tog_d[i]  = ~tog_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tog_q[i] <= 1'b0;
      else if (tog_en[i]) tog_q[i] <= tog_d[i];
    end
  end

  assign tog = tog_q;
endmodule

// File: rtl/sbg_fail_hold.sv
module sbg_fail_hold
  import sbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_i,
  input  logic fail_i,
  input  logic clr_i,
  output logic fail_q,
  output op_e  op_q
);
  logic fail_d;
  logic cap_en;

  always_comb begin
    cap_en = fail_i & ~fail_q & ~clr_i;
    if (clr_i)       fail_d = 1'b0;
    else if (fail_i) fail_d = 1'b1;
    else             fail_d = fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= OP_NONE;
    else if (cap_en) op_q <= op_i;
  end

  // R6: a held failure only ends through the reset command
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr_i) |=> fail_q);
endmodule

// File: rtl/sbg_encode.sv
module sbg_encode
  import sbg_pkg::*;
(
  input  op_e               op,
  input  phase_e            phase,
  input  logic              failed,
  input  logic              suspended,
  input  logic              d7,
  input  logic              in_sect,
  input  logic [N_TOG-1:0]  tog,
  output logic [STAT_W-1:0] status,
  output logic              use_array,
  output logic [N_TOG-1:0]  adv
);
  logic busy;

  always_comb begin
    busy      = (op != OP_NONE) && (failed || (phase != PH_DONE));
    status    = '0;
    use_array = 1'b1;
    adv       = '0;
    if (suspended && (op != OP_PROG)) begin
      if (in_sect) begin
        use_array      = 1'b0;
        status[B_POLL] = 1'b1;
        status[B_TOG]  = tog[T_MAIN];
        status[B_SECT] = tog[T_SECT];
        adv[T_SECT]    = 1'b1;
      end
    end else if (busy) begin
      use_array       = 1'b0;
      adv[T_MAIN]     = 1'b1;
      status[B_TOG]   = tog[T_MAIN];
      status[B_LIMIT] = failed;
      if (op == OP_PROG) begin
        status[B_POLL] = ~d7;
      end else begin
        status[B_POLL] = 1'b0;
        status[B_WIN]  = (op == OP_SECT) && (failed || (phase != PH_WINDOW));
        status[B_SECT] = tog[T_SECT];
        adv[T_SECT]    = (op == OP_CHIP) || in_sect;
      end
    end
  end
endmodule

// File: rtl/status_byte_gen.sv
module status_byte_gen
  import sbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_kind,
  input  logic [1:0] phase,
  input  logic       suspended,
  input  logic       prog_d7,
  input  logic       rd_stb,
  input  logic       rd_in_erase,
  input  logic       rst_cmd,
  output logic [7:0] status,
  output logic       use_array
);
  logic             rst_s;
  logic             rise;
  logic             fail_q;
  op_e              fail_op;
  op_e              op_in;
  op_e              op_eff;
  phase_e           ph_in;
  logic             fail_now;
  logic             failed;
  logic [N_TOG-1:0] adv;
  logic [N_TOG-1:0] tog;

  always_comb begin
    op_in    = op_e'(op_kind);
    ph_in    = phase_e'(phase);
    fail_now = (ph_in == PH_FAIL) && (op_in != OP_NONE);
    op_eff   = fail_q ? fail_op : op_in;
    failed   = fail_q | fail_now;
  end

  sbg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  sbg_read_edge u_edge (
    .clk(clk), .rst_n(rst_s), .rd_stb(rd_stb), .rise(rise)
  );

  sbg_fail_hold u_fail (
    .clk(clk), .rst_n(rst_s), .op_i(op_in), .fail_i(fail_now),
    .clr_i(rst_cmd), .fail_q(fail_q), .op_q(fail_op)
  );

  sbg_toggle #(.N(N_TOG)) u_tog (
    .clk(clk), .rst_n(rst_s), .rise(rise), .adv(adv), .tog(tog)
  );

  sbg_encode u_enc (
    .op(op_eff), .phase(ph_in), .failed(failed), .suspended(suspended),
    .d7(prog_d7), .in_sect(rd_in_erase), .tog(tog),
    .status(status), .use_array(use_array), .adv(adv)
  );

  // R4: without a strobe edge the flip state stays put
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_stb |=> $stable(tog));
  a_r4_level_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_stb && $past(rd_stb)) |=> $stable(tog));
  // R1: program polling bit
  a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_s)
    (!fail_q && !suspended && op_kind == 2'b01 && phase == 2'b01)
      |-> (status[7] == !prog_d7));
  // R2: erase polling bit
  a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_s)
    (!fail_q && !suspended && op_kind[1] && phase == 2'b01)
      |-> (!status[7] && !use_array));
  // R5: time-limit flag
  a_r5_limit: assert property (@(posedge clk) disable iff (!rst_s)
    (!suspended && phase == 2'b11 && op_kind != 2'b00) |-> status[5]);
  // R9: suspended read of an erased sector
  a_r9_susp_sect: assert property (@(posedge clk) disable iff (!rst_s)
    (!fail_q && suspended && op_kind[1] && rd_in_erase)
      |-> (status[7] && !use_array));
  // R10: suspended read elsewhere passes array data
  a_r10_susp_other: assert property (@(posedge clk) disable iff (!rst_s)
    (!fail_q && suspended && op_kind[1] && !rd_in_erase) |-> use_array);
endmodule

// File: tb/sim_status_byte_gen.sv
module sim_status_byte_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_kind;
  logic [1:0] phase;
  logic       suspended;
  logic       prog_d7;
  logic       rd_stb;
  logic       rd_in_erase;
  logic       rst_cmd;
  logic [7:0] status;
  logic       use_array;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  status_byte_gen u0 (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .phase(phase),
    .suspended(suspended), .prog_d7(prog_d7), .rd_stb(rd_stb),
    .rd_in_erase(rd_in_erase), .rst_cmd(rst_cmd),
    .status(status), .use_array(use_array)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one read: strobe rises at a falling edge, sample before the next rising edge
  task automatic rd(output logic [7:0] s, output logic ua);
    @(negedge clk);
    rd_stb = 1'b1;
    #1;
    s  = status;
    ua = use_array;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_op(input logic [1:0] op, input logic [1:0] ph);
    @(negedge clk);
    op_kind = op;
    phase   = ph;
  endtask

  task automatic t_reset;
    #1;
    chk(use_array == 1'b1, "R12 use_array", use_array, 1);
    chk(status == 8'h00, "R12 status", status, 0);
  endtask

  task automatic t_program;
    logic [7:0] a, b;
    logic ua;
    prog_d7 = 1'b1;
    set_op(2'b01, 2'b01);
    rd(a, ua);
    rd(b, ua);
    chk(a[7] == 1'b0, "R1 bit7 inverse of 1", a[7], 0);
    chk((a & 8'h3F) == 8'h00, "R1 low bits zero", a & 8'h3F, 0);
    chk(b[6] != a[6], "R3 bit6 flips", b[6], !a[6]);
    prog_d7 = 1'b0;
    rd(a, ua);
    chk(a[7] == 1'b1, "R1 bit7 inverse of 0", a[7], 1);
    chk(a[6] != b[6], "R3 bit6 flips again", a[6], !b[6]);
    set_op(2'b01, 2'b10);
    rd(a, ua);
    chk(ua == 1'b1 && a == 8'h00, "R3 done passes data", {ua, a}, 9'h100);
  endtask

  task automatic t_hold;
    logic [7:0] a, b, c;
    prog_d7 = 1'b0;
    set_op(2'b01, 2'b01);
    #1;
    a = status;
    repeat (6) @(negedge clk);
    #1;
    chk(status == a, "R4 idle cycles no change", status, a);
    @(negedge clk);
    rd_stb = 1'b1;
    #1;
    b = status;
    repeat (5) @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
    #1;
    c = status;
    chk(c[6] == !b[6], "R4 held strobe flips once", c[6], !b[6]);
  endtask

  task automatic t_chip;
    logic [7:0] a, b;
    logic ua;
    rd_in_erase = 1'b0;
    set_op(2'b10, 2'b01);
    rd(a, ua);
    rd(b, ua);
    chk(a[7] == 1'b0 && ua == 1'b0, "R2 chip erase poll", {ua, a[7]}, 0);
    chk(a[3] == 1'b0, "R7 chip bit3 zero", a[3], 0);
    chk(b[2] != a[2], "R8 chip bit2 flips", b[2], !a[2]);
    chk(b[6] != a[6], "R3 chip bit6 flips", b[6], !a[6]);
  endtask

  task automatic t_sector;
    logic [7:0] a, b;
    logic ua;
    rd_in_erase = 1'b0;
    set_op(2'b11, 2'b00);
    rd(a, ua);
    chk(a[3] == 1'b0 && a[7] == 1'b0, "R7 window bit3 zero", a, 0);
    set_op(2'b11, 2'b01);
    rd(b, ua);
    chk(b[3] == 1'b1, "R7 running bit3 one", b[3], 1);
    chk(b[2] == a[2], "R8 other sector bit2 holds", b[2], a[2]);
    rd_in_erase = 1'b1;
    rd(a, ua);
    rd(b, ua);
    chk(b[2] != a[2], "R8 erased sector bit2 flips", b[2], !a[2]);
  endtask

  task automatic t_fail;
    logic [7:0] a, b;
    logic ua;
    prog_d7 = 1'b1;
    set_op(2'b01, 2'b11);
    rd(a, ua);
    rd(b, ua);
    chk(a[5] == 1'b1, "R5 limit flag", a[5], 1);
    chk(a[7] == 1'b0, "R5 bit7 in-progress", a[7], 0);
    chk(b[6] != a[6], "R5 bit6 keeps flipping", b[6], !a[6]);
    set_op(2'b01, 2'b10);
    rd(a, ua);
    chk(a[5] == 1'b1 && ua == 1'b0, "R6 failure held", {ua, a[5]}, 1);
    @(negedge clk);
    rst_cmd = 1'b1;
    @(negedge clk);
    rst_cmd = 1'b0;
    rd(a, ua);
    chk(ua == 1'b1 && a == 8'h00, "R6 cleared by command", {ua, a}, 9'h100);
  endtask

  task automatic t_suspend;
    logic [7:0] a, b;
    logic ua, ub;
    suspended   = 1'b1;
    rd_in_erase = 1'b1;
    set_op(2'b11, 2'b01);
    rd(a, ua);
    rd(b, ub);
    chk(a[7] == 1'b1 && ua == 1'b0, "R9 bit7 one", {ua, a[7]}, 1);
    chk(b[6] == a[6], "R9 bit6 frozen", b[6], a[6]);
    chk(b[2] != a[2], "R9 bit2 flips", b[2], !a[2]);
    rd_in_erase = 1'b0;
    rd(a, ua);
    chk(ua == 1'b1, "R10 other sector data", ua, 1);
    prog_d7 = 1'b0;
    set_op(2'b01, 2'b01);
    rd(a, ua);
    rd(b, ub);
    chk(a[7] == 1'b1 && a[5] == 1'b0, "R11 suspended program", {a[7], a[5]}, 2);
    chk(b[6] != a[6], "R11 bit6 flips", b[6], !a[6]);
    suspended = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_kind = 2'b00; phase = 2'b10; suspended = 1'b0;
    prog_d7 = 1'b0; rd_stb = 1'b0; rd_in_erase = 1'b0; rst_cmd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_hold();
    t_chip();
    t_sector();
    t_fail();
    t_suspend();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule